// File: doc/BRIEF.md
# Hot-plug detect interrupt unit

This unit watches the hot-plug detect wire of a display transmitter. The raw wire is asynchronous to the unit's clock, so it first passes through a flop synchronizer. It then goes through a programmable glitch filter, which yields a clean connection level: 1 means a sink is attached and 0 means none is.

Each change of that level latches a sticky event. A connection latches a rise event and a disconnection latches a fall event, and both can be pending together. A third sticky source records the interrupt line of an attached transmitter core, which lets that core share the unit's single interrupt output. Software reaches the unit through a plain word-wide register port. Writes are strobed. Reads are combinational and have no side effects.

Register map (word addresses):

| Address | Register | Use |
|---|---|---|
| 0 | event status | pending events, read-only |
| 1 | event clear | write 1 to clear a bit; reads 0 |
| 2 | event enable | 1 lets a source reach the interrupt output |
| 3 | filter setup | filter threshold and prescaler |
| 4 | level | the filtered connection level |

Top module: `hpd_irq_unit`

## Requirements
- R1: The filtered level takes the synchronized input's value only after the two have disagreed on threshold+1 consecutive sample ticks, where threshold is filter-setup bits [7:0]. A shorter excursion leaves the level, and every event bit, unchanged.
- R2: A sample tick occurs once every prescale+1 clocks, where prescale is filter-setup bits [15:12]. Filter setup (address 3) reads back only these two fields; every other bit reads 0.
- R3: Status bit 0 (address 0) becomes 1 on the clock after core_irq_i is sampled high, and stays 1 until it is cleared.
- R4: A 0-to-1 change of the filtered level sets status bit 1 (rise). A 1-to-0 change sets status bit 2 (fall). Both bits can be 1 at the same time.
- R5: Writing to address 1 clears each status bit whose data bit is 1 and leaves the other status bits unchanged. An event arriving in the same cycle as its clear leaves the bit set. Writes to address 0 have no effect.
- R6: Enable (address 2, bits [2:0]) is active-high and can be read and written. irq_o is 1 exactly when some status bit and its enable bit are both 1.
- R7: Address 4 bit 0 reads the filtered level: 1 means connected, 0 means disconnected.
- R8: After reset, status, enable, filter setup and the filtered level all read 0, and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Unit clock |
| rst_ni | input | 1 | Asynchronous active-low reset; release is synchronized inside the unit |
| hpd_raw_i | input | 1 | Raw hot-plug wire, asynchronous |
| core_irq_i | input | 1 | Interrupt request from the attached core, synchronous to clk_i |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bound checker watches a fixed set of properties on every cycle:
- the filtered level holds whenever it already agrees with the synchronized input;
- each level change lands in the matching status bit one clock later;
- a core request always sets bit 0;
- a clear empties its bit unless a new event collides with it;
- irq_o stays low while all sources are masked.

Some behaviour only the bench scenarios can show: the exact pulse length the filter accepts or rejects, the slowdown the prescaler adds, field readback, read-modify-write of the enables, set-wins ordering seen through the port, and the reset values.

// File: rtl/hpd_irq_pkg.sv
package hpd_irq_pkg;
  // register port geometry
  localparam int REG_AW = 3;
  localparam int DATA_W = 32;

  // word addresses
  localparam logic [REG_AW-1:0] ADDR_STATUS = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_CLEAR  = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_ENABLE = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_FILTER = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_LEVEL  = 3'd4;

  // event sources, bit positions in status and enable
  localparam int NUM_SRC  = 3;
  localparam int SRC_CORE = 0;
  localparam int SRC_RISE = 1;
  localparam int SRC_FALL = 2;

  // lowest bit of the prescale field in the filter setup word
  localparam int PRE_LSB = 12;
endpackage

// File: rtl/hpd_sync.sv
// Flop chain with asynchronous clear. It serves as the data synchronizer and,
// with d_i tied high, as the reset-release synchronizer.
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hpd_glitch_filter.sv
// Prescaled stability filter. The level follows the input only after
// thr_i+1 consecutive ticks of disagreement. Rise and fall pulses are
// registered in the same edge as the level update.
module hpd_glitch_filter #(
  parameter int PRE_W = 4,
  parameter int THR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [PRE_W-1:0] pcnt_q, pcnt_d;
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             level_q, level_d;
  logic             rise_q, rise_d;
  logic             fall_q, fall_d;
  logic             tick;

  // prescaler: one tick every pre_i+1 clocks
  always_comb begin
    tick   = (pcnt_q >= pre_i);
    pcnt_d = tick ? '0 : pcnt_q + 1'b1;
  end

  // stability counter and level update
  always_comb begin
    cnt_d   = cnt_q;
    level_d = level_q;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    if (sync_i == level_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q >= thr_i) begin
        level_d = sync_i;
        cnt_d   = '0;
        rise_d  = sync_i;
        fall_d  = !sync_i;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q  <= '0;
      cnt_q   <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      pcnt_q  <= pcnt_d;
      cnt_q   <= cnt_d;
      level_q <= level_d;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
    end
  end

  assign level_o = level_q;
  assign rise_o  = rise_q;
  assign fall_o  = fall_q;
endmodule

// File: rtl/hpd_irq_regs.sv
// Register set: sticky status with write-one-to-clear (a new event wins over
// a clear), active-high enables, filter setup, level readback and the
// combined interrupt.
module hpd_irq_regs
  import hpd_irq_pkg::*;
#(
  parameter int PRE_W = 4,
  parameter int THR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [REG_AW-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               level_i,
  output logic [PRE_W-1:0]   pre_o,
  output logic [THR_W-1:0]   thr_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] status_q, status_d;
  logic [NUM_SRC-1:0] enable_q, enable_d;
  logic [PRE_W-1:0]   pre_q, pre_d;
  logic [THR_W-1:0]   thr_q, thr_d;
  logic [NUM_SRC-1:0] clr_mask;
  logic               en_wr, flt_wr;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_comb begin
    clr_mask = (wr_i && addr_i == ADDR_CLEAR) ? wdata_i[NUM_SRC-1:0] : '0;
    en_wr    = wr_i && (addr_i == ADDR_ENABLE);
    flt_wr   = wr_i && (addr_i == ADDR_FILTER);
  end

  // next state; the event term is ORed in after the clear, so a new event
  // wins over a clear in the same cycle
  always_comb begin
    status_d = (status_q & ~clr_mask) | evt_i;
    enable_d = en_wr  ? wdata_i[NUM_SRC-1:0]       : enable_q;
    pre_d    = flt_wr ? wdata_i[PRE_LSB +: PRE_W]  : pre_q;
    thr_d    = flt_wr ? wdata_i[THR_W-1:0]         : thr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      pre_q    <= '0;
      thr_q    <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      pre_q    <= pre_d;
      thr_q    <= thr_d;
    end
  end

  // side-effect-free read mux
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_STATUS: rdata_o[NUM_SRC-1:0] = status_q;
      ADDR_ENABLE: rdata_o[NUM_SRC-1:0] = enable_q;
      ADDR_FILTER: begin
        rdata_o[PRE_LSB +: PRE_W] = pre_q;
        rdata_o[THR_W-1:0]        = thr_q;
      end
      ADDR_LEVEL:  rdata_o[0] = level_i;
      default:     rdata_o = '0;
    endcase
  end

  assign pre_o = pre_q;
  assign thr_o = thr_q;
  assign irq_o = |(status_q & enable_q);
endmodule

// File: rtl/hpd_irq_unit.sv
module hpd_irq_unit
  import hpd_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 4,
  parameter int THR_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hpd_raw_i,
  input  logic              core_irq_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic               rst_sync_n;
  logic               hpd_sync_q;
  logic               level;
  logic               rise_pulse, fall_pulse;
  logic [PRE_W-1:0]   pre_cfg;
  logic [THR_W-1:0]   thr_cfg;
  logic [NUM_SRC-1:0] evt;

  // reset: asserted asynchronously, released on the clock
  hpd_sync #(.STAGES(2)) u_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  hpd_sync #(.STAGES(SYNC_STAGES)) u_hpd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .d_i   (hpd_raw_i),
    .q_o   (hpd_sync_q)
  );

  hpd_glitch_filter #(.PRE_W(PRE_W), .THR_W(THR_W)) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .sync_i (hpd_sync_q),
    .pre_i  (pre_cfg),
    .thr_i  (thr_cfg),
    .level_o(level),
    .rise_o (rise_pulse),
    .fall_o (fall_pulse)
  );

  always_comb begin
    evt           = '0;
    evt[SRC_CORE] = core_irq_i;
    evt[SRC_RISE] = rise_pulse;
    evt[SRC_FALL] = fall_pulse;
  end

  hpd_irq_regs #(.PRE_W(PRE_W), .THR_W(THR_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .wr_i   (reg_wr_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o),
    .evt_i  (evt),
    .level_i(level),
    .pre_o  (pre_cfg),
    .thr_o  (thr_cfg),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/hpd_irq_unit_checker.sv
module hpd_irq_unit_checker
  import hpd_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               sync_i,
  input logic               level_i,
  input logic               rise_i,
  input logic               fall_i,
  input logic               core_irq_i,
  input logic               wr_i,
  input logic [REG_AW-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [NUM_SRC-1:0] status_i,
  input logic [NUM_SRC-1:0] enable_i,
  input logic               irq_i
);
  // R1: an input that agrees with the level never moves it
  a_r1_hold_on_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i == level_i) |=> $stable(level_i));

  // R3: a core request is recorded
  a_r3_core_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_irq_i |=> status_i[SRC_CORE]);

  // R4: level changes reach the status bits
  a_r4_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_i) |=> status_i[SRC_RISE]);

  a_r4_fall_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level_i) |=> status_i[SRC_FALL]);

  // R5: a clear with no colliding event empties the bit
  a_r5_clear_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CLEAR && wdata_i[SRC_RISE] && !rise_i)
      |=> !status_i[SRC_RISE]);

  a_r5_clear_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_CLEAR && wdata_i[SRC_FALL] && !fall_i)
      |=> !status_i[SRC_FALL]);

  // R6: masked sources never raise the output
  a_r6_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i == '0) |-> !irq_i);
endmodule

bind hpd_irq_unit hpd_irq_unit_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_sync_n),
  .sync_i    (hpd_sync_q),
  .level_i   (level),
  .rise_i    (rise_pulse),
  .fall_i    (fall_pulse),
  .core_irq_i(core_irq_i),
  .wr_i      (reg_wr_i),
  .addr_i    (reg_addr_i),
  .wdata_i   (reg_wdata_i),
  .status_i  (u_regs.status_q),
  .enable_i  (u_regs.enable_q),
  .irq_i     (irq_o)
);

// File: tb/hpd_irq_unit_test.sv
`timescale 1ns/1ps
module hpd_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hpd_raw;
  logic        core_irq;
  logic        wr;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  hpd_irq_unit uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .hpd_raw_i  (hpd_raw),
    .core_irq_i (core_irq),
    .reg_wr_i   (wr),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  // vector: {pulse value, pulse length, final value, expected level, expected {fall,rise}}
  localparam int NV = 6;
  localparam logic [12:0] VECS [NV] = '{
    {1'b1, 8'd3,  1'b0, 1'b0, 2'b00},  // too short: rejected
    {1'b1, 8'd4,  1'b0, 1'b0, 2'b11},  // exactly thr+1: accepted, then drops
    {1'b1, 8'd2,  1'b1, 1'b1, 2'b01},  // connect
    {1'b0, 8'd3,  1'b1, 1'b1, 2'b00},  // short dropout rejected
    {1'b0, 8'd10, 1'b1, 1'b1, 2'b11},  // long dropout: fall then rise
    {1'b0, 8'd1,  1'b0, 1'b0, 2'b10}   // disconnect
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; hpd_raw = 1'b0; core_irq = 1'b0;
    wr = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    reg_read(3'd0, v); check("R8 status", v, 32'h0);
    reg_read(3'd2, v); check("R8 enable", v, 32'h0);
    reg_read(3'd3, v); check("R8 filter", v, 32'h0);
    reg_read(3'd4, v); check("R8 level", v, 32'h0);
    check("R8 irq", {31'b0, irq}, 32'h0);

    // R2 field readback
    reg_write(3'd3, 32'h0000_A0A0);
    reg_read(3'd3, v); check("R2 filter readback", v, 32'h0000_A0A0);
    reg_write(3'd3, 32'hFFFF_FFFF);
    reg_read(3'd3, v); check("R2 filter unused bits", v, 32'h0000_F0FF);

    // R1/R4 table: prescale 0, threshold 3
    reg_write(3'd3, 32'h0000_0003);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      hpd_raw = VECS[i][12];
      repeat (int'(VECS[i][11:4])) @(negedge clk);
      hpd_raw = VECS[i][3];
      repeat (20) @(negedge clk);
      reg_read(3'd4, v);
      check($sformatf("R1 R7 vector %0d level", i), v, {31'b0, VECS[i][2]});
      reg_read(3'd0, v);
      check($sformatf("R4 vector %0d status", i), v, {29'b0, VECS[i][1:0], 1'b0});
      reg_write(3'd1, 32'h7);
    end

    // R2 prescale 3, threshold 2: needs 3 ticks, about 12 clocks
    reg_write(3'd3, 32'h0000_3002);
    @(negedge clk); hpd_raw = 1'b1;
    repeat (6) @(negedge clk); hpd_raw = 1'b0;
    repeat (20) @(negedge clk);
    reg_read(3'd4, v); check("R2 prescaled pulse rejected level", v, 32'h0);
    reg_read(3'd0, v); check("R2 prescaled pulse no event", v, 32'h0);
    @(negedge clk); hpd_raw = 1'b1;
    repeat (8) @(negedge clk);
    reg_read(3'd4, v); check("R2 prescaler slows acceptance", v, 32'h0);
    repeat (30) @(negedge clk);
    reg_read(3'd4, v); check("R2 R7 prescaled connect", v, 32'h1);
    reg_read(3'd0, v); check("R4 prescaled rise", v, 32'h2);

    // R6 masking and read-modify-write of the enables
    check("R6 masked irq", {31'b0, irq}, 32'h0);
    reg_write(3'd2, 32'h2);
    @(negedge clk); check("R6 rise enabled irq", {31'b0, irq}, 32'h1);
    reg_read(3'd2, v);
    reg_write(3'd2, v | 32'h4);
    reg_read(3'd2, v); check("R6 enable rmw", v, 32'h6);
    reg_write(3'd2, 32'h4);
    @(negedge clk); check("R6 rise masked again", {31'b0, irq}, 32'h0);

    // R5 writes to status are ignored
    reg_write(3'd0, 32'h0);
    reg_read(3'd0, v); check("R5 status write ignored", v, 32'h2);

    // R3 core request is sticky
    @(negedge clk); core_irq = 1'b1;
    @(negedge clk); core_irq = 1'b0;
    repeat (3) @(negedge clk);
    reg_read(3'd0, v); check("R3 core sticky", v, 32'h3);
    reg_write(3'd2, 32'h1);
    @(negedge clk); check("R3 R6 core irq", {31'b0, irq}, 32'h1);

    // R5 selective clear
    reg_write(3'd1, 32'h2);
    reg_read(3'd0, v); check("R5 selective clear", v, 32'h1);

    // R5 set wins over a colliding clear
    @(negedge clk);
    core_irq = 1'b1; wr = 1'b1; addr = 3'd1; wdata = 32'h1;
    @(negedge clk);
    core_irq = 1'b0; wr = 1'b0; wdata = '0;
    reg_read(3'd0, v); check("R5 set wins", v, 32'h1);
    reg_write(3'd1, 32'h1);
    reg_read(3'd0, v); check("R5 clear after collision", v, 32'h0);
    @(negedge clk); check("R6 irq drops", {31'b0, irq}, 32'h0);

    // R8 reset mid-run returns everything to zero
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1; hpd_raw = 1'b0;
    repeat (4) @(negedge clk);
    reg_read(3'd4, v); check("R8 level after reset", v, 32'h0);
    reg_read(3'd2, v); check("R8 enable after reset", v, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule